// File: doc/BRIEF.md
# Strobe-Acknowledged Read Slave

This block answers read cycles from an asynchronous processor bus whose strobes are active low and whose acknowledge line is shared between several slaves. Everything runs on one internal clock. The chip-select, data-strobe and direction inputs pass through a multi-stage synchronizer. Once a qualified read is recognized, the block captures the word address and issues a one-clock request on an internal register-file read port. It then waits a variable number of clocks for a ready pulse carrying the data.

The acknowledge line is driven in four steps. It first drives high to precharge the shared line, then drives low to acknowledge, then drives high again for one clock once the cycle ends, and finally returns to high impedance. The data bus drives the fetched word from the clock after capture until the strobes go away. The acknowledge is held inside a bounded window: it never comes before a minimum count, and a time-out substitutes a fixed pattern when the register file is late. After each cycle a minimum idle gap must pass before a new one is accepted, and a cycle whose strobes vanish before the acknowledge is abandoned cleanly.

Top module: `strobe_rd_slave`

## Requirements
- R1: A read begins only when cs_n and ds_n are both 0, rd_wr is 1 (1 = read) and addr_en is 1. The strobes are seen through a two-stage synchronizer. With the gap satisfied, fetch_req is high for exactly one clock, on the third rising edge after the strobes are applied, and fetch_addr then equals addr.
- R2: With rd_wr at 0, or with addr_en at 0, held strobes produce no fetch_req and the acknowledge stays undriven (ack_oe = 0).
- R3: ack_oe rises with ack_val = 1 two clocks after fetch_req is seen, and this happens before any low acknowledge.
- R4: The acknowledge (ack_oe = 1, ack_val = 0) asserts at the later of two points: 7 clocks after fetch_req is seen, or 2 clocks after fetch_rdy is presented.
- R5: data_oe is high with the fetched word on data_out from the clock after capture, which is at least one clock before the acknowledge asserts.
- R6: If fetch_rdy never comes, data_out drives 16'hDEAD 54 clocks after fetch_req is seen, and the acknowledge asserts one clock later. Measured from fetch_req, the acknowledge always lands between 7 and 55 clocks.
- R7: When a strobe de-asserts, the acknowledge stays low for two more clocks. It is then driven high for one clock with data_oe already 0, and after that ack_oe returns to 0.
- R8: De-asserting ds_n alone ends the cycle exactly as de-asserting cs_n does.
- R9: After a cycle ends, no new fetch_req is issued until 4 idle clocks have passed. Strobes re-applied at once yield fetch_req 9 clocks after the ending strobe edge.
- R10: If the strobes go away before the acknowledge asserts, the block skips the low phase, drives high for one clock, releases, and still enforces the idle gap.
- R11: fetch_rdy outside a pending fetch is ignored: data_out does not change while the acknowledge is asserted, and data_oe stays 0 while idle.
- R12: While rst is high and after it, with no cycle, ack_oe, data_oe and fetch_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal master clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rd_wr | input | 1 | Direction, 1 = read |
| addr_en | input | 1 | Address qualifier, must be 1 for a read |
| addr | input | 15 | Word address |
| data_out | output | 16 | Read data toward the pad |
| data_oe | output | 1 | Data bus drive enable |
| ack_oe | output | 1 | Acknowledge drive enable |
| ack_val | output | 1 | Acknowledge driven value (0 = acknowledge) |
| fetch_req | output | 1 | One-clock request to the register file |
| fetch_addr | output | 15 | Address captured for the request |
| fetch_rdy | input | 1 | Register file ready pulse |
| fetch_data | input | 16 | Register file data, valid with fetch_rdy |

## Verification
Reads are run over a table of ready latencies: immediate, short, equal to the minimum window, beyond it, and never. The early latencies show that the acknowledge is held back to the minimum count. The later ones show it tracking the data plus one clock, and the absent ready shows the time-out pattern and the upper bound. Cycles ending by chip select versus by data strobe alone show that either strobe closes the cycle. An immediate re-assertion after a cycle, and an abandon before the acknowledge, show the idle gap measured exactly. Write-direction and unqualified-address strobes, and stray ready pulses while idle or acknowledged, show the inputs the block must ignore.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ACK   = 2'd2,
    ST_REL   = 2'd3
  } srd_state_e;
endpackage

// File: rtl/srd_sync.sv
// Multi-stage synchronizer, one chain per bit, with per-bit reset value.
module srd_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/srd_fetch.sv
// Internal read port: request pulse, ready capture, time-out substitution.
module srd_fetch #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] TMO_WORD = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              tmo,
  input  logic              clr,
  input  logic              rdy,
  input  logic [DATA_W-1:0] rdata,
  output logic              req,
  output logic [ADDR_W-1:0] req_addr,
  output logic              dvalid,
  output logic [DATA_W-1:0] dout
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      req_addr <= '0;
      pending  <= 1'b0;
      dvalid   <= 1'b0;
      dout     <= '0;
    end else begin
      req <= start;
      if (start) begin
        req_addr <= addr_in;
        pending  <= 1'b1;
      end
      if (clr) begin
        pending <= 1'b0;
        dvalid  <= 1'b0;
        dout    <= '0;
      end else if (pending && (rdy || tmo)) begin
        // a real ready wins over a coincident time-out
        dout    <= rdy ? rdata : TMO_WORD;
        dvalid  <= 1'b1;
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srd_seq.sv
// Cycle sequencer: gap enforcement, window counter, acknowledge phases.
module srd_seq
  import srd_pkg::*;
#(
  parameter int unsigned PRE_CLKS = 2,
  parameter int unsigned MIN_ACK  = 7,
  parameter int unsigned TMO      = 54,
  parameter int unsigned GAP      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic rd,
  input  logic aen,
  input  logic dvalid,
  output logic start,
  output logic tmo,
  output logic go_rel,
  output logic ack_oe,
  output logic ack_val
);
  localparam int unsigned CNT_W = $clog2(TMO + 2);
  localparam int unsigned GAP_W = $clog2(GAP + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [GAP_W-1:0] GAP_V   = GAP_W'(GAP);

  srd_state_e st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [GAP_W-1:0] gap, gap_n;

  always_comb begin
    st_n  = st;
    cnt_n = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    gap_n = gap;
    start = 1'b0;
    unique case (st)
      ST_IDLE: begin
        cnt_n = cnt;
        if (gap < GAP_V) gap_n = gap + 1'b1;
        if (sel && rd && aen && gap >= GAP_V) begin
          st_n  = ST_FETCH;
          cnt_n = '0;
          start = 1'b1;
        end
      end
      ST_FETCH: begin
        if (!sel) st_n = ST_REL;
        else if (dvalid && cnt_n >= CNT_W'(MIN_ACK)) st_n = ST_ACK;
      end
      ST_ACK: if (!sel) st_n = ST_REL;
      ST_REL: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
    if (st_n == ST_REL && st != ST_REL) gap_n = '0;
  end

  assign tmo    = (st == ST_FETCH) && (cnt == CNT_W'(TMO - 1));
  assign go_rel = (st_n == ST_REL) && (st != ST_REL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      gap     <= GAP_V;
      ack_oe  <= 1'b0;
      ack_val <= 1'b1;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      gap     <= gap_n;
      ack_oe  <= (st_n == ST_FETCH && cnt_n >= CNT_W'(PRE_CLKS)) ||
                 st_n == ST_ACK || st_n == ST_REL;
      ack_val <= (st_n != ST_ACK);
    end
  end
endmodule

// File: rtl/strobe_rd_slave.sv
module strobe_rd_slave #(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned STAGES   = 2,
  parameter int unsigned PRE_CLKS = 2,
  parameter int unsigned MIN_ACK  = 7,
  parameter int unsigned TMO      = 54,
  parameter int unsigned GAP      = 4,
  parameter logic [DATA_W-1:0] TMO_WORD = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic              rd_wr,
  input  logic              addr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              ack_oe,
  output logic              ack_val,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_rdy,
  input  logic [DATA_W-1:0] fetch_data
);
  logic [2:0] ctl_s;
  logic sel, start, tmo, go_rel, dvalid;

  srd_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b110)) sync_i (
    .clk(clk), .rst(rst), .d_async({cs_n, ds_n, rd_wr}), .q_sync(ctl_s)
  );

  assign sel = !ctl_s[2] && !ctl_s[1];

  srd_seq #(.PRE_CLKS(PRE_CLKS), .MIN_ACK(MIN_ACK), .TMO(TMO), .GAP(GAP)) seq_i (
    .clk(clk), .rst(rst), .sel(sel), .rd(ctl_s[0]), .aen(addr_en),
    .dvalid(dvalid), .start(start), .tmo(tmo), .go_rel(go_rel),
    .ack_oe(ack_oe), .ack_val(ack_val)
  );

  srd_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_WORD(TMO_WORD)) fetch_i (
    .clk(clk), .rst(rst), .start(start), .addr_in(addr), .tmo(tmo),
    .clr(go_rel), .rdy(fetch_rdy), .rdata(fetch_data), .req(fetch_req),
    .req_addr(fetch_addr), .dvalid(dvalid), .dout(data_out)
  );

  assign data_oe = dvalid;
endmodule

// File: rtl/strobe_rd_slave_chk.sv
module strobe_rd_slave_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned MIN_ACK = 7,
  parameter int unsigned TMO     = 54
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_req,
  input logic              ack_oe,
  input logic              ack_val,
  input logic              data_oe,
  input logic [DATA_W-1:0] data_out
);
  localparam int unsigned WW = $clog2(TMO + 4);
  logic [WW-1:0] win;
  logic ack_on;
  assign ack_on = ack_oe && !ack_val;

  always_ff @(posedge clk) begin
    if (rst) win <= '0;
    else if (fetch_req) win <= '0;
    else if (win != {WW{1'b1}}) win <= win + 1'b1;
  end

  assert_req_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    fetch_req |=> !fetch_req);
  assert_precharge_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_oe) |-> ack_val);
  assert_data_first_R5: assert property (@(posedge clk) disable iff (rst)
    (ack_on && !$past(ack_on)) |-> $past(data_oe));
  assert_window_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_on && !$past(ack_on)) |-> (win >= WW'(MIN_ACK - 1) && win <= WW'(TMO)));
  assert_release_high_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_oe) |-> $past(ack_val) && !data_oe);
  assert_data_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (ack_on && $past(ack_on)) |-> $stable(data_out));
endmodule

bind strobe_rd_slave strobe_rd_slave_chk #(.DATA_W(DATA_W), .MIN_ACK(MIN_ACK), .TMO(TMO)) chk_i (
  .clk(clk), .rst(rst), .fetch_req(fetch_req), .ack_oe(ack_oe),
  .ack_val(ack_val), .data_oe(data_oe), .data_out(data_out)
);

// File: tb/strobe_rd_slave_tb_top.sv
module strobe_rd_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {addr[14:0], latency[7:0] (255 = no ready), data[15:0], end_by_ds, reassert}
  localparam logic [40:0] VEC [NVEC] = '{
    {15'h0001, 8'd0,   16'h1234, 1'b0, 1'b0},
    {15'h2A55, 8'd3,   16'hBEEF, 1'b1, 1'b0},
    {15'h7FFF, 8'd5,   16'h0F0F, 1'b0, 1'b0},
    {15'h1000, 8'd9,   16'hA5A5, 1'b1, 1'b0},
    {15'h0333, 8'd30,  16'hC001, 1'b0, 1'b1},
    {15'h4444, 8'd255, 16'h7777, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, ds_n = 1'b1, rd_wr = 1'b1, addr_en = 1'b0;
  logic [14:0] addr = '0;
  logic [15:0] data_out, fetch_data = '0;
  logic data_oe, ack_oe, ack_val, fetch_req, fetch_rdy = 1'b0;
  logic [14:0] fetch_addr;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  strobe_rd_slave dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ds_n(ds_n), .rd_wr(rd_wr),
    .addr_en(addr_en), .addr(addr), .data_out(data_out), .data_oe(data_oe),
    .ack_oe(ack_oe), .ack_val(ack_val), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_rdy(fetch_rdy), .fetch_data(fetch_data)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic run_read(input logic [14:0] a, input int lat, input logic [15:0] d,
                          input bit by_ds, input bit reassert);
    int req_k = -1, oe_k = -1, ack_k = -1, dv_k = -1, exp_ack, exp_dv;
    logic [15:0] exp_d;
    bit early_low = 0, late_req = 0;
    exp_d   = (lat < 200) ? d : 16'hDEAD;
    exp_dv  = (lat < 200) ? 4 + lat : 57;
    exp_ack = (lat < 200) ? ((5 + lat > 10) ? 5 + lat : 10) : 58;
    @(negedge clk);
    cs_n = 0; ds_n = 0; rd_wr = 1; addr_en = 1; addr = a;
    for (int k = 1; k <= 70 && ack_k < 0; k++) begin
      @(negedge clk);
      fetch_rdy = 0;
      if (fetch_req && req_k < 0) begin
        req_k = k;
        chk(fetch_addr == a, "R1", "fetch_addr", fetch_addr, a);
      end
      if (ack_oe && oe_k < 0) begin
        oe_k = k;
        chk(ack_val == 1'b1, "R3", "first drive high", ack_val, 1);
      end
      if (data_oe && dv_k < 0) dv_k = k;
      if (ack_oe && !ack_val) ack_k = k;
      if (req_k >= 0 && k == req_k + lat && lat < 200) begin
        fetch_rdy = 1; fetch_data = d;
      end
    end
    chk(req_k == 3, "R1", "fetch_req clock", req_k, 3);
    chk(oe_k == 5, "R3", "precharge clock", oe_k, 5);
    chk(dv_k == exp_dv, (lat < 200) ? "R5" : "R6", "data_oe clock", dv_k, exp_dv);
    chk(ack_k == exp_ack, (lat < 200) ? "R4" : "R6", "ack clock", ack_k, exp_ack);
    chk(data_out == exp_d, (lat < 200) ? "R5" : "R6", "data at ack", data_out, exp_d);
    // stray ready while acknowledged
    fetch_rdy = 1; fetch_data = ~d;
    @(negedge clk);
    fetch_rdy = 0;
    chk(data_out == exp_d && ack_oe && !ack_val, "R11", "data hold", data_out, exp_d);
    if (by_ds) ds_n = 1; else cs_n = 1;
    @(negedge clk);
    if (reassert) begin cs_n = 0; ds_n = 0; end
    chk(ack_oe && !ack_val && data_oe, by_ds ? "R8" : "R7", "ack hold 1", ack_val, 0);
    @(negedge clk);
    chk(ack_oe && !ack_val, "R7", "ack hold 2", ack_val, 0);
    @(negedge clk);
    chk(ack_oe && ack_val && !data_oe, by_ds ? "R8" : "R7", "release high", {ack_oe, ack_val, data_oe}, 3'b110);
    @(negedge clk);
    chk(!ack_oe, "R7", "released", ack_oe, 0);
    if (reassert) begin
      for (int j = 5; j <= 9; j++) begin
        @(negedge clk);
        if (fetch_req != (j == 9)) late_req = 1;
      end
      chk(!late_req, "R9", "gap re-accept at +9", late_req, 0);
    end
    cs_n = 1; ds_n = 1; addr_en = 0;
    repeat (12) @(negedge clk);
    chk(!ack_oe && !data_oe && !early_low, "R7", "idle after cycle", ack_oe, 0);
  endtask

  task automatic hold_no_cycle(input string rq);
    bit seen = 0;
    @(negedge clk);
    cs_n = 0; ds_n = 0; addr = 15'h0055;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (fetch_req || ack_oe) seen = 1;
    end
    chk(!seen, rq, "no cycle", seen, 0);
    cs_n = 1; ds_n = 1; rd_wr = 1; addr_en = 0;
    repeat (10) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin : main
    bit bad;
    repeat (3) @(negedge clk);
    chk(!ack_oe && !data_oe && !fetch_req, "R12", "in reset", {ack_oe, data_oe, fetch_req}, 0);
    rst = 0;
    repeat (6) @(negedge clk);
    chk(!ack_oe && !data_oe && !fetch_req, "R12", "after reset", {ack_oe, data_oe, fetch_req}, 0);

    for (int v = 0; v < NVEC; v++)
      run_read(VEC[v][40:26], int'(VEC[v][25:18]) == 255 ? 255 : int'(VEC[v][25:18]),
               VEC[v][17:2], VEC[v][1], VEC[v][0]);

    // R2: write direction, then missing address qualifier
    rd_wr = 0; addr_en = 1;
    hold_no_cycle("R2");
    rd_wr = 1; addr_en = 0;
    hold_no_cycle("R2");

    // R10: abandon before acknowledge, immediate re-assert, gap still enforced
    bad = 0;
    @(negedge clk);
    cs_n = 0; ds_n = 0; rd_wr = 1; addr_en = 1; addr = 15'h0101;
    repeat (5) @(negedge clk);
    chk(ack_oe && ack_val, "R10", "precharge before abandon", ack_val, 1);
    @(negedge clk); cs_n = 1;
    @(negedge clk); cs_n = 0;
    for (int k = 8; k <= 15; k++) begin
      @(negedge clk);
      if (ack_oe && !ack_val) bad = 1;
      if (data_oe) bad = 1;
      if (k == 9 && !(ack_oe && ack_val)) bad = 1;
      if (k == 10 && ack_oe) bad = 1;
      if (fetch_req != (k == 15)) bad = 1;
    end
    chk(!bad, "R10", "abandon sequence and gap", bad, 0);
    cs_n = 1; ds_n = 1; addr_en = 0;
    repeat (12) @(negedge clk);

    // R11: stray ready while idle
    bad = 0;
    fetch_rdy = 1; fetch_data = 16'h5A5A;
    @(negedge clk); fetch_rdy = 0;
    repeat (4) begin
      @(negedge clk);
      if (data_oe || fetch_req || ack_oe) bad = 1;
    end
    chk(!bad, "R11", "idle ready ignored", bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule